// File: doc/BRIEF.md
# Synchronous Clock Enable Divider Chain

This block turns a 25.175 MHz system clock into three slow timing signals: a 100 Hz strobe and a 5 Hz strobe, each one input clock cycle wide, and a 1 Hz square wave. All three are meant to be used as enables or level inputs by logic running on the same clock. None of them is a derived clock, so every downstream flop stays in one clock domain.

The chain is built from modulo-N counter stages. Each stage counts only while its count enable is high, raises its terminal count output for the one enabled cycle in which it sits at N-1, and wraps to zero on that cycle. Three stages in series (25, 1007 and 10 by default) produce the 100 Hz strobe. Two stages hang off that strobe in parallel: a divide-by-20 that gives the 5 Hz strobe, and a divide-by-50 whose 2 Hz strobe drives a two-state toggle machine that gives the 1 Hz square wave. Every divisor is a parameter, so a simulation can shrink the counts.

Top module: `sync_divider_chain`

## Requirements
- R1: While `clr` is high, and without any clock edge, every counter and the toggle state read zero, so all three outputs are 0; after release, cycle 0 is the first cycle and counting restarts from zero.
- R2: A counter stage's terminal count is high exactly in a cycle where its count equals its divisor minus one and its enable is high, and the count becomes zero on the next edge.
- R3: A counter stage holds its count in every cycle in which its enable is low, so no strobe appears between its scheduled cycles.
- R4: `pulse_100hz` is high for exactly one cycle in each period of B = PRE_DIV*MID_DIV*DEC_DIV cycles, first in cycle B-1 after release (in cycles k with k mod B = B-1).
- R5: `pulse_5hz` is high for one cycle in each period of SLOW_DIV*B cycles, in cycles k with k mod (SLOW_DIV*B) = SLOW_DIV*B-1, and is only ever high in a cycle where `pulse_100hz` is also high.
- R6: `square_1hz` starts low after release and changes level on the edge that ends each cycle in which the HALF_DIV-th `pulse_100hz` strobe of a group occurs, so it is high in cycles k with floor(k/(HALF_DIV*B)) odd, giving an exact 50% duty.
- R7: All five divisors are parameters (defaults 25, 1007, 10, 20, 50), each must be at least 2, and smaller values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (25.175 MHz in the target use) |
| clr | input | 1 | Asynchronous clear, active high |
| pulse_100hz | output | 1 | One-cycle strobe every B cycles |
| pulse_5hz | output | 1 | One-cycle strobe every SLOW_DIV*B cycles |
| square_1hz | output | 1 | Square wave with period 2*HALF_DIV*B cycles |

## Verification
The bench shrinks the divisors and checks the exact cycle of each strobe after release. An off-by-one terminal count would move the first strobe to cycle B-2 or B. A strobe that lasts two cycles, or a stage that keeps counting while disabled, would show up as extra strobes in the run totals. The square wave is checked at both sides of each transition and for equal high and low cycle counts, which catches a toggle that fires one strobe early. The clear is raised between clock edges while the square wave is high, so a clear that waits for a clock edge leaves an output set when it is sampled. The first strobe after the restart must again land in cycle B-1.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   // Count register width for a modulo-n counter (at least one bit).
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Two-state toggle machine encoding.
   typedef enum logic {
      TS_LOW  = 1'b0,
      TS_HIGH = 1'b1
   } tog_state_e;

endpackage

// File: rtl/cascade_stage.sv
module cascade_stage
   import clkdiv_pkg::*;
#(
   parameter int unsigned MODULUS = 10
) (
   input  logic clk,
   input  logic clr,
   input  logic ce,
   output logic tc
);

   localparam int unsigned W    = cnt_width(MODULUS);
   localparam logic [W-1:0] LAST = W'(MODULUS - 1);

   generate
      if (MODULUS < 2) begin : g_bad_modulus
         $error("cascade_stage: MODULUS must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;
   logic         at_last;

   // Next-state and output logic.
   always_comb begin
      at_last = (cnt_q == LAST);
      cnt_d   = cnt_q;
      if (ce) begin
         cnt_d = at_last ? '0 : cnt_q + 1'b1;
      end
      tc = ce & at_last;
   end

   // State register with asynchronous clear.
   always_ff @(posedge clk or posedge clr) begin
      if (clr) cnt_q <= '0;
      else     cnt_q <= cnt_d;
   end

   // R2: after a terminal count the stage restarts at zero
   a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (clr)
      tc |=> (cnt_q == '0));

   // R2: the count never leaves the range 0..MODULUS-1
   a_r2_in_range: assert property (@(posedge clk) disable iff (clr)
      cnt_q <= LAST);

   // R3: a disabled stage keeps its count
   a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (clr)
      !ce |=> $stable(cnt_q));

endmodule

// File: rtl/toggle_fsm.sv
module toggle_fsm
   import clkdiv_pkg::*;
(
   input  logic clk,
   input  logic clr,
   input  logic t,
   output logic q
);

   tog_state_e st_q;
   tog_state_e st_d;

   // Next-state logic.
   always_comb begin
      unique case (st_q)
         TS_LOW:  st_d = t ? TS_HIGH : TS_LOW;
         TS_HIGH: st_d = t ? TS_LOW  : TS_HIGH;
         default: st_d = TS_LOW;
      endcase
   end

   // State register with asynchronous clear.
   always_ff @(posedge clk or posedge clr) begin
      if (clr) st_q <= TS_LOW;
      else     st_q <= st_d;
   end

   // Output logic.
   assign q = (st_q == TS_HIGH);

   // R6: each toggle request flips the level on the next edge
   a_r6_flip_on_request: assert property (@(posedge clk) disable iff (clr)
      t |=> (q != $past(q)));

   // R6: without a request the level holds
   a_r6_hold_otherwise: assert property (@(posedge clk) disable iff (clr)
      !t |=> $stable(q));

endmodule

// File: rtl/sync_divider_chain.sv
module sync_divider_chain
   import clkdiv_pkg::*;
#(
   parameter int unsigned PRE_DIV  = 25,
   parameter int unsigned MID_DIV  = 1007,
   parameter int unsigned DEC_DIV  = 10,
   parameter int unsigned SLOW_DIV = 20,
   parameter int unsigned HALF_DIV = 50
) (
   input  logic clk,
   input  logic clr,
   output logic pulse_100hz,
   output logic pulse_5hz,
   output logic square_1hz
);

   localparam int unsigned NSER = 3;
   localparam int unsigned SERIAL_DIV [NSER] = '{PRE_DIV, MID_DIV, DEC_DIV};

   // en[i] enables serial stage i; en[NSER] is the base strobe.
   logic [NSER:0] en;
   logic          half_tick;

   assign en[0] = 1'b1;

   generate
      for (genvar i = 0; i < NSER; i++) begin : g_serial
         cascade_stage #(.MODULUS(SERIAL_DIV[i])) u_stage (
            .clk (clk),
            .clr (clr),
            .ce  (en[i]),
            .tc  (en[i+1])
         );
      end
   endgenerate

   assign pulse_100hz = en[NSER];

   // Branch stages run side by side off the base strobe.
   cascade_stage #(.MODULUS(SLOW_DIV)) u_slow (
      .clk (clk),
      .clr (clr),
      .ce  (pulse_100hz),
      .tc  (pulse_5hz)
   );

   cascade_stage #(.MODULUS(HALF_DIV)) u_half (
      .clk (clk),
      .clr (clr),
      .ce  (pulse_100hz),
      .tc  (half_tick)
   );

   toggle_fsm u_toggle (
      .clk (clk),
      .clr (clr),
      .t   (half_tick),
      .q   (square_1hz)
   );

   // R5: the slow strobe coincides with a base strobe
   a_r5_slow_on_base: assert property (@(posedge clk) disable iff (clr)
      pulse_5hz |-> pulse_100hz);

   // R4: the base strobe is never two cycles long
   a_r4_single_cycle: assert property (@(posedge clk) disable iff (clr)
      pulse_100hz |=> !pulse_100hz);

   // R6: the square wave only moves on a half-period tick
   a_r6_edge_needs_tick: assert property (@(posedge clk) disable iff (clr)
      !half_tick |=> $stable(square_1hz));

endmodule

// File: tb/test_sync_divider_chain.sv
module test_sync_divider_chain;

   localparam int P0 = 3, P1 = 4, P2 = 2, SL = 5, HF = 3;
   localparam int BASE = P0 * P1 * P2;     // 24
   localparam int SLOWP = SL * BASE;       // 120
   localparam int HALFP = HF * BASE;       // 72
   localparam int NVEC = 13;

   // {cycle k [11:3], expected pulse_100hz, pulse_5hz, square_1hz}
   localparam logic [11:0] VEC [NVEC] = '{
      {9'd1,   3'b000}, {9'd22,  3'b000}, {9'd23,  3'b100},
      {9'd24,  3'b000}, {9'd47,  3'b100}, {9'd71,  3'b100},
      {9'd72,  3'b001}, {9'd119, 3'b111}, {9'd120, 3'b001},
      {9'd143, 3'b101}, {9'd144, 3'b000}, {9'd216, 3'b001},
      {9'd239, 3'b111}
   };

   logic clk = 1'b0;
   logic clr = 1'b1;
   logic pulse_100hz, pulse_5hz, square_1hz;

   int n_total = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   sync_divider_chain #(
      .PRE_DIV(P0), .MID_DIV(P1), .DEC_DIV(P2), .SLOW_DIV(SL), .HALF_DIV(HF)
   ) i_sync_divider_chain (
      .clk         (clk),
      .clr         (clr),
      .pulse_100hz (pulse_100hz),
      .pulse_5hz   (pulse_5hz),
      .square_1hz  (square_1hz)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_total++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         summary();
      end
   end

   initial begin
      int vi, n100, n5, nhi, nlo, prev100;
      // R1: outputs are zero while clear is held
      repeat (4) @(negedge clk);
      check(pulse_100hz == 1'b0, "R1 reset p100", pulse_100hz, 0);
      check(pulse_5hz   == 1'b0, "R1 reset p5",   pulse_5hz, 0);
      check(square_1hz  == 1'b0, "R1 reset sq",   square_1hz, 0);

      clr = 1'b0;  // released at a falling edge: cycle 0 begins
      vi = 0; n100 = 0; n5 = 0; nhi = 0; nlo = 0; prev100 = 0;
      for (int k = 1; k <= 370; k++) begin
         @(negedge clk);
         if (k <= 4 * HALFP) begin
            n100 += pulse_100hz;
            n5   += pulse_5hz;
            if (square_1hz) nhi++; else nlo++;
            // R2: a strobe never lasts two cycles
            if (prev100 == 1 && pulse_100hz)
               check(1'b0, "R2 double strobe", 1, 0);
            prev100 = pulse_100hz;
         end
         if (vi < NVEC && k == int'(VEC[vi][11:3])) begin
            check(pulse_100hz == VEC[vi][2], $sformatf("R4 p100 k=%0d", k), pulse_100hz, VEC[vi][2]);
            check(pulse_5hz   == VEC[vi][1], $sformatf("R5 p5 k=%0d", k),   pulse_5hz,   VEC[vi][1]);
            check(square_1hz  == VEC[vi][0], $sformatf("R6 sq k=%0d", k),   square_1hz,  VEC[vi][0]);
            vi++;
         end
      end

      // R3 R7: strobe totals over four half periods match the scaled divisors
      check(n100 == 4 * HALFP / BASE, "R3 R7 p100 count", n100, 4 * HALFP / BASE);
      check(n5 == 4 * HALFP / SLOWP, "R5 p5 count", n5, 4 * HALFP / SLOWP);
      // R6: equal high and low time
      check(nhi == 2 * HALFP, "R6 duty high", nhi, 2 * HALFP);
      check(nlo == 2 * HALFP, "R6 duty low", nlo, 2 * HALFP);

      // Cycle 370 lies in an odd half period: square wave is high.
      check(square_1hz == 1'b1, "R6 sq k=370", square_1hz, 1);

      // R1: clear mid-cycle takes effect with no clock edge
      #1 clr = 1'b1;
      #1;
      check(square_1hz == 1'b0, "R1 async sq", square_1hz, 0);
      check(pulse_100hz == 1'b0, "R1 async p100", pulse_100hz, 0);
      check(pulse_5hz == 1'b0, "R1 async p5", pulse_5hz, 0);

      repeat (3) @(negedge clk);
      clr = 1'b0;
      n100 = 0;
      for (int k = 1; k <= BASE; k++) begin
         @(negedge clk);
         if (k == BASE - 2)
            check(pulse_100hz == 1'b0, "R1 restart early", pulse_100hz, 0);
         if (k == BASE - 1)
            check(pulse_100hz == 1'b1, "R1 restart first strobe", pulse_100hz, 1);
         if (k == BASE)
            check(pulse_100hz == 1'b0, "R2 restart one cycle", pulse_100hz, 0);
      end

      done = 1'b1;
      summary();
   end

endmodule